// File: doc/BRIEF.md
# Delayed-Branch Macro Sequencer

This block is the program counter and control sequencer of a small macro processor. A host writes 32-bit instruction words into a program RAM through a load port and then pulses a start strobe. The sequencer issues one instruction per clock, from address zero upward. It shows each instruction word and its address on registered outputs. Decode logic outside the block returns five signals for the issued word: the branch flag, the branch sense, the annul flag, the signed word offset and the exit flag. The same outside logic supplies the value of the register that the branch tests.

Branches test the supplied operand for zero or for non-zero. A taken branch that is not annulled first issues the next sequential instruction, its delay slot, and then the target. An annulled taken branch goes straight to its target and skips that slot. An exit flag lets exactly one more instruction issue and then ends the run. That last instruction is chosen by the normal branch rules, so an exit placed in a delay slot still reaches the branch target.

A run also ends when the next address falls outside the loaded program. A branch placed in a delay slot is a fault: it stops the run and raises an error flag. The ALU datapath and the dispatch of results are handled elsewhere.

Top module: `macro_seq`

## Requirements
- R1: After reset, busy, done and error are all low.
- R2: A start strobe with a non-empty program makes busy high on the next cycle, with instr_pc at 0 and instr_word holding the word stored at that address. While busy, one instruction issues per cycle, and busy and done are never high together.
- R3: A branch is taken when the operand is zero and the sense input is low, or when the operand is non-zero and the sense input is high. An untaken branch continues with the sequential address, as a non-branch does.
- R4: The branch target is the address of the branch plus the sign-extended offset input. Negative offsets move backward.
- R5: After a taken branch with annul low, the instruction at the branch address plus one issues next as a delay slot, and the target issues after it.
- R6: After a taken branch with annul high, the target issues next and the following instruction does not issue.
- R7: After an instruction with the exit flag high, exactly one more instruction issues, selected by R3 to R6. An exit in a delay slot makes the target the last instruction. An exit on a taken non-annulled branch makes its delay slot the last instruction.
- R8: A branch issued in a delay slot ends the run with error and done high, and no further instruction issues.
- R9: The program length is one plus the address of the most recent load write. When the next address is negative or not below the length, the run ends with done high and error low.
- R10: A start strobe, even in the middle of a run, restarts at address 0. It clears done, error, the pending delay slot and the pending exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Program RAM write enable |
| load_addr | input | AW | Program RAM write address |
| load_data | input | DW | Instruction word to write |
| start | input | 1 | Start or restart strobe |
| cond_operand | input | DW | Value of the register tested by the issued branch |
| dec_branch | input | 1 | Issued word is a conditional branch |
| dec_on_nonzero | input | 1 | Branch sense: 1 branches on non-zero, 0 on zero |
| dec_annul | input | 1 | Taken branch skips its delay slot |
| dec_offset | input | OFFW | Signed word offset of the branch target |
| dec_exit | input | 1 | Exit flag of the issued word |
| instr_word | output | DW | Issued instruction word |
| instr_pc | output | AW | Address of the issued instruction |
| busy | output | 1 | An instruction is issued this cycle |
| done | output | 1 | Run has ended |
| error | output | 1 | Run ended on a branch in a delay slot |

## Verification
Several functions can land on the same instruction. An exit can sit on a delay-slot instruction, and it can sit on a taken non-annulled branch. In both cases the exit countdown and the pending slot decide the last instruction together. A start strobe can also arrive while a delay slot is pending. Short programs set up each of these cases. The bench decodes the issued word by its own field layout (bit 31 branch, bit 30 sense, bit 29 annul, bit 28 exit, bits 15:8 operand, bits 7:0 offset). It judges each run by comparing the full sequence of issued addresses, and the final done and error levels, with a sequence worked out from the requirements.

// File: rtl/macro_seq_pkg.sv
package macro_seq_pkg;
  typedef enum logic [1:0] {
    STOP_NONE  = 2'd0,
    STOP_CLEAN = 2'd1,
    STOP_FAULT = 2'd2
  } stop_e;
endpackage

// File: rtl/seq_prog_ram.sv
module seq_prog_ram #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/seq_branch_resolve.sv
module seq_branch_resolve
  import macro_seq_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 6,
  parameter int OFFW = 8,
  parameter int SW   = ((AW > OFFW) ? AW : OFFW) + 2
) (
  input  logic [AW-1:0]        cur_pc,
  input  logic                 in_slot,
  input  logic signed [SW-1:0] slot_tgt,
  input  logic                 final_i,
  input  logic [AW:0]          prog_len,
  input  logic                 dec_branch,
  input  logic                 dec_on_nonzero,
  input  logic                 dec_annul,
  input  logic [OFFW-1:0]      dec_offset,
  input  logic                 dec_exit,
  input  logic [DW-1:0]        cond_operand,
  output logic                 taken,
  output logic signed [SW-1:0] target,
  output logic [AW-1:0]        nxt_pc,
  output logic                 nxt_slot,
  output logic                 nxt_final,
  output stop_e                stop
);
  logic                 cond_zero;
  logic signed [SW-1:0] pc_ext, off_ext, seq_addr, chosen;
  logic [SW-1:0]        len_ext;
  logic                 in_range;

  always_comb begin
    cond_zero = (cond_operand == '0);
    taken     = dec_branch & (dec_on_nonzero ? ~cond_zero : cond_zero);
    pc_ext    = {{(SW-AW){1'b0}}, cur_pc};
    off_ext   = {{(SW-OFFW){dec_offset[OFFW-1]}}, dec_offset};
    target    = pc_ext + off_ext;
    seq_addr  = pc_ext + {{(SW-1){1'b0}}, 1'b1};

    if (in_slot)                chosen = slot_tgt;
    else if (taken & dec_annul) chosen = target;
    else                        chosen = seq_addr;

    len_ext   = {{(SW-AW-1){1'b0}}, prog_len};
    in_range  = ~chosen[SW-1] && ($unsigned(chosen) < len_ext);
    nxt_pc    = chosen[AW-1:0];
    nxt_slot  = ~in_slot & taken & ~dec_annul;
    nxt_final = dec_exit;

    if (in_slot & dec_branch)      stop = STOP_FAULT;
    else if (final_i || !in_range) stop = STOP_CLEAN;
    else                           stop = STOP_NONE;
  end
endmodule

// File: rtl/macro_seq.sv
module macro_seq
  import macro_seq_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 6,
  parameter int OFFW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_we,
  input  logic [AW-1:0]   load_addr,
  input  logic [DW-1:0]   load_data,
  input  logic            start,
  input  logic [DW-1:0]   cond_operand,
  input  logic            dec_branch,
  input  logic            dec_on_nonzero,
  input  logic            dec_annul,
  input  logic [OFFW-1:0] dec_offset,
  input  logic            dec_exit,
  output logic [DW-1:0]   instr_word,
  output logic [AW-1:0]   instr_pc,
  output logic            busy,
  output logic            done,
  output logic            error
);
  localparam int SW = ((AW > OFFW) ? AW : OFFW) + 2;
  localparam logic [AW:0] LEN_ONE = 1;

  logic                 busy_q, done_q, err_q, slot_q, final_q;
  logic [AW-1:0]        pc_q;
  logic signed [SW-1:0] slot_tgt_q;
  logic [AW:0]          len_q;

  logic                 taken, nxt_slot, nxt_final;
  logic signed [SW-1:0] target;
  logic [AW-1:0]        nxt_pc, rd_addr;
  stop_e                stop;

  assign rd_addr = start ? '0 : nxt_pc;

  seq_prog_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (load_we),
    .waddr (load_addr),
    .wdata (load_data),
    .raddr (rd_addr),
    .rdata (instr_word)
  );

  seq_branch_resolve #(.DW(DW), .AW(AW), .OFFW(OFFW), .SW(SW)) u_resolve (
    .cur_pc         (pc_q),
    .in_slot        (slot_q),
    .slot_tgt       (slot_tgt_q),
    .final_i        (final_q),
    .prog_len       (len_q),
    .dec_branch     (dec_branch),
    .dec_on_nonzero (dec_on_nonzero),
    .dec_annul      (dec_annul),
    .dec_offset     (dec_offset),
    .dec_exit       (dec_exit),
    .cond_operand   (cond_operand),
    .taken          (taken),
    .target         (target),
    .nxt_pc         (nxt_pc),
    .nxt_slot       (nxt_slot),
    .nxt_final      (nxt_final),
    .stop           (stop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      slot_q     <= 1'b0;
      final_q    <= 1'b0;
      pc_q       <= '0;
      slot_tgt_q <= '0;
      len_q      <= '0;
    end else begin
      if (load_we) len_q <= {1'b0, load_addr} + LEN_ONE;
      if (start) begin
        pc_q    <= '0;
        slot_q  <= 1'b0;
        final_q <= 1'b0;
        err_q   <= 1'b0;
        busy_q  <= (len_q != '0);
        done_q  <= (len_q == '0);
      end else if (busy_q) begin
        unique case (stop)
          STOP_NONE: begin
            pc_q       <= nxt_pc;
            slot_q     <= nxt_slot;
            slot_tgt_q <= target;
            final_q    <= nxt_final;
          end
          STOP_CLEAN: begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
          default: begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end
        endcase
      end
    end
  end

  assign instr_pc = pc_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign error    = err_q;

  assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  assert_start_restarts_R10: assert property (@(posedge clk) disable iff (rst)
    (start && len_q != '0) |=> (busy && instr_pc == '0 && !error && !slot_q));

  assert_annul_jumps_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && stop == STOP_NONE && !slot_q && taken && dec_annul)
      |=> (busy && !slot_q && instr_pc == $past(target[AW-1:0])));

  assert_slot_then_target_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && stop == STOP_NONE && slot_q)
      |=> (busy && instr_pc == $past(slot_tgt_q[AW-1:0])));

  assert_exit_one_more_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && final_q) |=> (!busy && done));

  assert_slot_branch_fault_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && slot_q && dec_branch) |=> (error && done && !busy));

  assert_error_idle_R8: assert property (@(posedge clk) disable iff (rst)
    error |-> (!busy && done));
endmodule

// File: tb/macro_seq_tb.sv
module macro_seq_tb;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int OFFW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_we = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [DW-1:0] load_data = '0;
  logic start = 1'b0;
  logic [DW-1:0] instr_word;
  logic [AW-1:0] instr_pc;
  logic busy, done, error;

  always #2 clk = ~clk;

  // bench field layout of an instruction word
  wire            dec_branch     = instr_word[31];
  wire            dec_on_nonzero = instr_word[30];
  wire            dec_annul      = instr_word[29];
  wire            dec_exit       = instr_word[28];
  wire [DW-1:0]   cond_operand   = {24'b0, instr_word[15:8]};
  wire [OFFW-1:0] dec_offset     = instr_word[7:0];

  macro_seq #(.DW(DW), .AW(AW), .OFFW(OFFW)) u_dut (
    .clk(clk), .rst(rst), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .start(start), .cond_operand(cond_operand),
    .dec_branch(dec_branch), .dec_on_nonzero(dec_on_nonzero),
    .dec_annul(dec_annul), .dec_offset(dec_offset), .dec_exit(dec_exit),
    .instr_word(instr_word), .instr_pc(instr_pc), .busy(busy),
    .done(done), .error(error)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] prog [16];
  int exp_tr [16];
  int tr [32];
  int tn;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mk(bit br, bit nz, bit an, bit ex, int cv, int off);
    return {br, nz, an, ex, 12'h000, cv[7:0], off[7:0]};
  endfunction

  localparam logic [31:0] NOP = 32'h0;
  localparam logic [31:0] EXIT = 32'h1000_0000;

  task automatic chk(bit ok, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  task automatic load_prog(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      load_we = 1'b1; load_addr = AW'(i); load_data = prog[i];
    end
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic capture();
    tn = 0;
    while (busy && tn < 32) begin
      tr[tn] = int'(instr_pc);
      tn++;
      @(negedge clk);
    end
  endtask

  task automatic go();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    capture();
  endtask

  task automatic cmp_trace(string req, int n, bit exp_err);
    chk(tn == n, {req, " trace length"}, tn, n);
    for (int i = 0; i < n && i < tn; i++)
      chk(tr[i] == exp_tr[i], {req, " issued address"}, tr[i], exp_tr[i]);
    chk(done == 1'b1, {req, " done"}, int'(done), 1);
    chk(error == exp_err, {req, " error"}, int'(error), int'(exp_err));
  endtask

  task automatic t_sequential();  // R2, R3 (non-zero test, not taken), R9
    prog[0] = NOP; prog[1] = mk(1,1,0,0,0,5); prog[2] = NOP;
    load_prog(3);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && instr_pc == 0, "R2 first issue at address 0", int'(instr_pc), 0);
    chk(instr_word == prog[0], "R2 word of address 0", int'(instr_word), int'(prog[0]));
    capture();
    exp_tr[0] = 0; exp_tr[1] = 1; exp_tr[2] = 2;
    cmp_trace("R2 R3 R9 sequential", 3, 1'b0);
  endtask

  task automatic t_delay_slot();  // R5, R4, R7
    prog[0] = NOP; prog[1] = mk(1,0,0,0,0,3); prog[2] = NOP; prog[3] = NOP;
    prog[4] = NOP; prog[5] = EXIT; prog[6] = NOP; prog[7] = NOP;
    load_prog(8);
    go();
    exp_tr[0]=0; exp_tr[1]=1; exp_tr[2]=2; exp_tr[3]=4; exp_tr[4]=5; exp_tr[5]=6;
    cmp_trace("R5 R7 delay slot then target", 6, 1'b0);
  endtask

  task automatic t_annul();  // R6, R3 (zero test, not taken), R7
    prog[0] = NOP; prog[1] = mk(1,1,1,0,5,2); prog[2] = NOP;
    prog[3] = mk(1,0,0,0,7,-3); prog[4] = EXIT; prog[5] = NOP; prog[6] = NOP;
    load_prog(7);
    go();
    exp_tr[0]=0; exp_tr[1]=1; exp_tr[2]=3; exp_tr[3]=4; exp_tr[4]=5;
    cmp_trace("R6 R3 annulled and untaken", 5, 1'b0);
  endtask

  task automatic t_exit_in_slot();  // R7
    prog[0] = mk(1,0,0,0,0,3); prog[1] = EXIT; prog[2] = NOP; prog[3] = NOP; prog[4] = NOP;
    load_prog(5);
    go();
    exp_tr[0]=0; exp_tr[1]=1; exp_tr[2]=3;
    cmp_trace("R7 exit in slot reaches target", 3, 1'b0);
  endtask

  task automatic t_exit_on_branch();  // R7
    prog[0] = mk(1,0,0,1,0,3); prog[1] = NOP; prog[2] = NOP; prog[3] = NOP;
    load_prog(4);
    go();
    exp_tr[0]=0; exp_tr[1]=1;
    cmp_trace("R7 exit on branch ends after slot", 2, 1'b0);
  endtask

  task automatic t_backward();  // R4 negative offset
    prog[0] = NOP; prog[1] = mk(1,0,1,0,0,3); prog[2] = EXIT; prog[3] = NOP;
    prog[4] = mk(1,0,1,0,0,-2);
    load_prog(5);
    go();
    exp_tr[0]=0; exp_tr[1]=1; exp_tr[2]=4; exp_tr[3]=2; exp_tr[4]=3;
    cmp_trace("R4 backward offset", 5, 1'b0);
  endtask

  task automatic t_slot_fault();  // R8
    prog[0] = mk(1,0,0,0,0,2); prog[1] = mk(1,0,0,0,9,1); prog[2] = NOP; prog[3] = NOP;
    load_prog(4);
    go();
    exp_tr[0]=0; exp_tr[1]=1;
    cmp_trace("R8 branch in slot", 2, 1'b1);
    repeat (3) @(negedge clk);
    chk(!busy, "R8 no issue after fault", int'(busy), 0);
  endtask

  task automatic t_out_of_range();  // R9, R10 clears error
    prog[0] = mk(1,0,1,0,0,10); prog[1] = NOP;
    load_prog(2);
    go();
    exp_tr[0]=0;
    cmp_trace("R9 R10 target past end", 1, 1'b0);
    prog[0] = NOP; prog[1] = mk(1,0,1,0,0,-5);
    load_prog(2);
    go();
    exp_tr[0]=0; exp_tr[1]=1;
    cmp_trace("R9 negative target", 2, 1'b0);
  endtask

  task automatic t_restart();  // R10 with a pending slot
    prog[0] = NOP; prog[1] = mk(1,0,0,0,0,3); prog[2] = NOP; prog[3] = NOP;
    prog[4] = NOP; prog[5] = EXIT; prog[6] = NOP; prog[7] = NOP;
    load_prog(8);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (busy && instr_pc != 1) @(negedge clk);
    @(negedge clk);
    chk(busy && instr_pc == 2, "R10 slot pending before restart", int'(instr_pc), 2);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    capture();
    exp_tr[0]=0; exp_tr[1]=1; exp_tr[2]=2; exp_tr[3]=4; exp_tr[4]=5; exp_tr[5]=6;
    cmp_trace("R10 restart mid-run", 6, 1'b0);
  endtask

  initial begin
    wait (cyc >= 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy, "R1 busy after reset", int'(busy), 0);
    chk(!done, "R1 done after reset", int'(done), 0);
    chk(!error, "R1 error after reset", int'(error), 0);
    t_sequential();
    t_delay_slot();
    t_annul();
    t_exit_in_slot();
    t_exit_on_branch();
    t_backward();
    t_slot_fault();
    t_out_of_range();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule